// File: doc/BRIEF.md
# Externally Clocked I2S Sample Serializer

This block sends a pair of held 24-bit audio samples out as one serial data line in I2S style. It works as a slave. The bit clock and the word select both come from outside, and the block never generates either of them. On the system clock it samples the two external clocks, finds their edges, and moves one bit to the serial line on each falling edge of the bit clock.

A change of word select picks the channel to send. Right is sent while word select is high, and left is sent while it is low. When the change is detected, the block copies the chosen sample into a private shift register. A later update of the sample inputs therefore cannot corrupt a word that is already on the line.

The block produces a pad enable for the serial line, so that a pad cell at the chip edge can tri-state it. A separate input reports that the incoming audio signal has been lost, and it forces the line low.

Top module: `i2sx_serializer`

## Requirements
- R1: When word select is high after a change, the right sample is sent; when it is low, the left sample is sent.
- R2: The serial output changes only in response to a detected falling edge of the external bit clock. It holds its value through the high phase and through the rest of the low phase.
- R3: After any word-select change, the first falling bit-clock edge detected after the change carries the MSB (bit 23) of the newly selected sample. The following edges carry bits 22 down to 0 in order.
- R4: When a word runs longer than 24 falling edges, every bit after the 24th is 0.
- R5: `serOutEn` is high exactly when `outEnable` is high. The pad drives the line only then and is high impedance otherwise.
- R6: While `sigLost` is high, `serOut` is 0. Shifting continues underneath, so the word position is kept.
- R7: The sample is captured when the word-select change is detected. A change of `leftSample` or `rightSample` after that point does not alter the word being sent.
- R8: During and after reset, `serOut` is 0 until the first word-select change has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least four times the bit-clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| leftSample | input | 24 | Latest left-channel sample |
| rightSample | input | 24 | Latest right-channel sample |
| bitClk | input | 1 | External serial bit clock (asynchronous) |
| wordSel | input | 1 | External word select, high = right (asynchronous) |
| outEnable | input | 1 | High lets the pad drive the serial line |
| sigLost | input | 1 | High forces the serial data low |
| serOut | output | 1 | Serial data, MSB first |
| serOutEn | output | 1 | Drive enable for the serial-line pad |

## Verification
The bench builds the block with its default parameters: 24-bit samples and a two-stage synchronizer. With these values a 32-edge word runs past the end of the sample, which exercises the zero fill. A 16-edge word is cut short by a word-select change, which exercises the restart at the MSB. The bit clock runs at one eighth of the system clock, with four system cycles in each phase. Each bit therefore lands a fixed three cycles after its falling edge, and the bench checks it at the end of the low phase.

// File: rtl/i2sx_pkg.sv
package i2sx_pkg;

  // Strobes from the control to the datapath; at most one action fires per cycle.
  typedef struct packed {
    logic load;      // capture the selected sample into the shift register
    logic selRight;  // channel to capture: 1 = right, 0 = left
    logic shift;     // present the next sample bit on the data line
    logic zero;      // word exhausted: present 0
  } serStrobe_t;

endpackage

// File: rtl/i2sx_sync.sv
module i2sx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/i2sx_ctrl.sv
module i2sx_ctrl
  import i2sx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclkSync,
  input  logic             wsSync,
  output serStrobe_t       strobe,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  logic bclkPrev;
  logic wsPrev;
  logic wsChange;
  logic fallEdge;

  always_comb begin
    wsChange        = wsSync ^ wsPrev;
    fallEdge        = bclkPrev & ~bclkSync;
    strobe.load     = wsChange;
    strobe.selRight = wsSync;
    strobe.shift    = !wsChange && fallEdge && (bitCount < FULL);
    strobe.zero     = !wsChange && fallEdge && (bitCount == FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      wsPrev   <= 1'b0;
      bitCount <= FULL;
    end else begin
      bclkPrev <= bclkSync;
      wsPrev   <= wsSync;
      if (strobe.load)       bitCount <= '0;
      else if (strobe.shift) bitCount <= bitCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/i2sx_dpath.sv
module i2sx_dpath
  import i2sx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  serStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                dataBit,
  output logic                shiftMsb
);

  logic [SAMPLE_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataBit  <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= strobe.selRight ? rightSample : leftSample;
    end else if (strobe.shift) begin
      dataBit  <= shiftReg[SAMPLE_W-1];
      shiftReg <= {shiftReg[SAMPLE_W-2:0], 1'b0};
    end else if (strobe.zero) begin
      dataBit  <= 1'b0;
    end
  end

  assign shiftMsb = shiftReg[SAMPLE_W-1];

endmodule

// File: rtl/i2sx_serializer.sv
module i2sx_serializer
  import i2sx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                bitClk,
  input  logic                wordSel,
  input  logic                outEnable,
  input  logic                sigLost,
  output logic                serOut,
  output logic                serOutEn
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic [1:0]       syncBus;
  serStrobe_t       strobe;
  logic [CNT_W-1:0] bitCount;
  logic             dataBit;
  logic             shiftMsb;

  i2sx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({bitClk, wordSel}),
    .syncOut (syncBus)
  );

  i2sx_ctrl #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bclkSync (syncBus[1]),
    .wsSync   (syncBus[0]),
    .strobe   (strobe),
    .bitCount (bitCount)
  );

  i2sx_dpath #(.SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .dataBit     (dataBit),
    .shiftMsb    (shiftMsb)
  );

  assign serOut   = dataBit & ~sigLost;
  assign serOutEn = outEnable;

endmodule

// File: rtl/i2sx_serializer_chk.sv
module i2sx_serializer_chk
  import i2sx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input serStrobe_t       strobe,
  input logic [CNT_W-1:0] bitCount,
  input logic             dataBit,
  input logic             shiftMsb
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.shift, strobe.zero})); // R2

  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shift || strobe.zero) |=> $stable(dataBit)); // R2

  AST_BIT_FROM_REGISTER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> dataBit == $past(shiftMsb)); // R3

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> bitCount == '0); // R3

  AST_SHIFT_IN_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> bitCount < FULL); // R4

  AST_ZERO_AFTER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> !dataBit); // R4

  always_ff @(posedge clk) begin
    if (rstN) AST_NO_OVERFLOW: assert (bitCount <= FULL); // R4
  end

endmodule

bind i2sx_serializer i2sx_serializer_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .bitCount (bitCount),
  .dataBit  (dataBit),
  .shiftMsb (shiftMsb)
);

// File: tb/i2sx_serializer_test.sv
module i2sx_serializer_test;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] leftSample = '0;
  logic [W-1:0] rightSample = '0;
  logic         bitClk = 1'b1;
  logic         wordSel = 1'b0;
  logic         outEnable = 1'b1;
  logic         sigLost = 1'b0;
  logic         serOut;
  logic         serOutEn;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;
  bit expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  i2sx_serializer uut (
    .clk(clk), .rstN(rstN), .leftSample(leftSample), .rightSample(rightSample),
    .bitClk(bitClk), .wordSel(wordSel), .outEnable(outEnable), .sigLost(sigLost),
    .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic check(input logic act, input logic exp, input string req);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Enable follows outEnable on every clock (R5).
  always @(negedge clk) if (rstN) check(serOutEn, outEnable, "R5 pad enable");

  // One bit-clock period: 4 clocks low, 4 clocks high; the bit is checked at the end of the low phase.
  task automatic bitCycle(input string req);
    logic exp;
    bitClk = 1'b0;
    repeat (4) @(negedge clk);
    exp = (expQ.size() > 0) ? expQ.pop_front() : 1'b0;
    check(serOut, exp & ~sigLost, req);
    bitClk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Change word select while the bit clock is high and queue the expected word.
  task automatic startWord(input logic ws);
    logic [W-1:0] s;
    wordSel = ws;
    s = ws ? rightSample : leftSample;
    expQ.delete();
    for (int i = W - 1; i >= 0; i--) expQ.push_back(s[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(serOut, 1'b0, "R8 in reset");
    rstN = 1'b1;
    leftSample  = 24'hA5C3F1;
    rightSample = 24'h3C96E7;
    @(negedge clk);
    // R8: no word-select change yet, line stays low
    for (int i = 0; i < 4; i++) bitCycle("R8 idle before first word");

    // R1/R3: right word, exactly 24 bits
    startWord(1'b1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < W; i++) bitCycle("R1 R3 right word");

    // R1/R3/R4: left word with 32 edges, last 8 must be zero
    startWord(1'b0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 32; i++) bitCycle(i < W ? "R1 R3 left word" : "R4 zero fill");

    // R3: short right word cut off after 16 bits, next word restarts at MSB
    rightSample = 24'hF0F00F;
    startWord(1'b1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) bitCycle("R3 short word");
    leftSample = 24'h800001;
    startWord(1'b0);
    repeat (4) @(negedge clk);
    // R7: change the sample inputs once the word is under way
    for (int i = 0; i < W; i++) begin
      if (i == 2) begin
        leftSample  = 24'h7FFFFE;
        rightSample = 24'h000000;
      end
      bitCycle("R3 R7 restart and hold captured sample");
    end

    // R6: lost signal forces low mid-word, shifting continues underneath
    rightSample = 24'hFFFFFF;
    startWord(1'b1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      sigLost = (i >= 4 && i < 12);
      bitCycle(sigLost ? "R6 forced low" : "R6 word position kept");
    end
    sigLost = 1'b0;

    // R5: enable low and high while a word runs
    leftSample = 24'h5A5A5A;
    startWord(1'b0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      outEnable = (i < 8 || i > 15);
      bitCycle("R5 R1 word with pad disabled");
    end

    // R2: line holds through a long high phase of the bit clock
    rightSample = 24'hC00000;
    startWord(1'b1);
    repeat (4) @(negedge clk);
    bitCycle("R2 first bit");
    repeat (12) begin
      @(negedge clk);
      check(serOut, 1'b1, "R2 hold in high phase");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule